// File: doc/BRIEF.md
# Time-Triggered Periodic Pulse Generator

This block produces pulses on two output pins at programmed instants of a running time-of-day. The time arrives on an input port as whole seconds plus nanoseconds. Each of the two channels holds a target instant. When the time reaches that instant, the channel drives its pin active for a width chosen from a fixed table. It then moves its target forward by a programmed period, so the pulses repeat at a fixed rate. Software sets up the block through 16-bit word writes. Each channel has its own target and period words. Both channels share one control word that holds, for each channel, a width code, an output polarity and a stop-reload flag.

A pulse train starts when software writes the channel's target. The last word of the target completes the write and arms the channel. Software writes a seconds value of all ones to stop a channel. A stopped channel never matches. Because pulse ends are measured against the same time input as the starts, the bench can move the time forward in jumps, which lets it reach long pulse widths in a short run.

Top module: `pulse_sched`

## Requirements
- R1: After reset, both pins are high, since reset clears all control bits. Neither pin pulses until software commits a target.
- R2: The control word is at address 0x01. Channel 0 uses bit 0 as stop-reload, bit 1 as polarity and bits 7:4 as width code. Channel 1 uses bit 2 as stop-reload, bit 3 as polarity and bits 11:8 as width code.
- R3: Channel 0 target words are at 0x15 to 0x18 and channel 1 target words are at 0x1F to 0x22. Each set holds, in address order: seconds high, seconds low, nanoseconds high, nanoseconds low. Writing the first three words changes nothing. The write of the nanoseconds-low word loads all four at once and arms the channel.
- R4: Channel 0 period words are at 0x19 to 0x1C and channel 1 period words are at 0x23 to 0x26. They use the same word order as the target words.
- R5: Bits 15:14 of any nanoseconds-high word are ignored. A nanoseconds value is 30 bits wide.
- R6: An armed channel matches when the sampled time is equal to or later than its target. Its pin goes active at the clock edge that samples that time.
- R7: The pin returns to idle at the edge that first samples a time at or after the matched target plus the width. Width codes 0 to 13 give, in order: 100 ns, 500 ns, 1 us, 5 us, 10 us, 50 us, 100 us, 500 us, 1 ms, 5 ms, 10 ms, 50 ms, 100 ms and 200 ms. Codes 14 and 15 give 200 ms.
- R8: With polarity 1 the pin idles low and pulses high. With polarity 0 the pin idles high and pulses low.
- R9: With stop-reload at 0, each match advances the target by the period. A nanosecond sum of 1,000,000,000 or more carries into the seconds.
- R10: With stop-reload at 1, a match produces one pulse and then disarms the channel until the next target commit.
- R11: A target seconds value of 0xFFFFFFFF never matches. A pulse already in progress still ends at its normal time.
- R12: The two channels work independently. Periods down to 200 ns are supported, provided the period is longer than the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register word write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | 16 | Register write data |
| now_sec | input | 32 | Current time, seconds |
| now_ns | input | 30 | Current time, nanoseconds (0 to 999,999,999) |
| pulse_out | output | 2 | Pulse pins, bit 0 for channel 0 and bit 1 for channel 1 |

## Verification
The bench builds the block with its default parameters: a 6-bit word address and the register map given above. It drives the time input forward by 4 ns per clock. Every target, period and width it uses is a multiple of 4 ns, so each edge should land exactly on a predicted instant. Because the time port can also jump, the bench reaches the 200 ms widths, whole-second periods and the carry across a seconds boundary within a few thousand cycles.

// File: rtl/pulse_sched_pkg.sv
`timescale 1ns/1ps
package pulse_sched_pkg;
  localparam int SEC_W  = 32;
  localparam int NS_W   = 30;
  localparam int WORD_W = 16;
  localparam int NSHI_W = NS_W - WORD_W;
  localparam int WID_W  = 28;
  localparam logic [NS_W:0] NS_WRAP = (NS_W+1)'(1000000000);

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } ptime_t;

  // a is at or after b
  function automatic logic time_ge(input ptime_t a, input ptime_t b);
    return (a.sec > b.sec) || ((a.sec == b.sec) && (a.ns >= b.ns));
  endfunction

  // sum of two times with nanosecond carry into seconds
  function automatic ptime_t time_add(input ptime_t a, input ptime_t d);
    logic [NS_W:0] s;
    ptime_t r;
    s     = {1'b0, a.ns} + {1'b0, d.ns};
    r.sec = a.sec + d.sec;
    if (s >= NS_WRAP) begin
      s     = s - NS_WRAP;
      r.sec = r.sec + 1'b1;
    end
    r.ns = s[NS_W-1:0];
    return r;
  endfunction

  // pulse width in nanoseconds for a 4-bit code
  function automatic logic [WID_W-1:0] width_ns(input logic [3:0] code);
    case (code)
      4'd0:    return WID_W'(100);
      4'd1:    return WID_W'(500);
      4'd2:    return WID_W'(1000);
      4'd3:    return WID_W'(5000);
      4'd4:    return WID_W'(10000);
      4'd5:    return WID_W'(50000);
      4'd6:    return WID_W'(100000);
      4'd7:    return WID_W'(500000);
      4'd8:    return WID_W'(1000000);
      4'd9:    return WID_W'(5000000);
      4'd10:   return WID_W'(10000000);
      4'd11:   return WID_W'(50000000);
      4'd12:   return WID_W'(100000000);
      default: return WID_W'(200000000);
    endcase
  endfunction
endpackage

// File: rtl/pulse_sched_chregs.sv
`timescale 1ns/1ps
module pulse_sched_chregs
  import pulse_sched_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int TGT_BASE = 'h15,
  parameter int PER_BASE = 'h19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              tgt_load,
  output ptime_t            tgt_value,
  output ptime_t            period
);
  localparam logic [ADDR_W-1:0] A_TSH = ADDR_W'(TGT_BASE);
  localparam logic [ADDR_W-1:0] A_TSL = ADDR_W'(TGT_BASE + 1);
  localparam logic [ADDR_W-1:0] A_TNH = ADDR_W'(TGT_BASE + 2);
  localparam logic [ADDR_W-1:0] A_TNL = ADDR_W'(TGT_BASE + 3);
  localparam logic [ADDR_W-1:0] A_PSH = ADDR_W'(PER_BASE);
  localparam logic [ADDR_W-1:0] A_PSL = ADDR_W'(PER_BASE + 1);
  localparam logic [ADDR_W-1:0] A_PNH = ADDR_W'(PER_BASE + 2);
  localparam logic [ADDR_W-1:0] A_PNL = ADDR_W'(PER_BASE + 3);

  // staged target words, committed by the nanoseconds-low write
  logic [WORD_W-1:0] tsh_q, tsl_q;
  logic [NSHI_W-1:0] tnh_q;
  logic [WORD_W-1:0] psh_q, psl_q, pnl_q;
  logic [NSHI_W-1:0] pnh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tsh_q <= '0; tsl_q <= '0; tnh_q <= '0;
      psh_q <= '0; psl_q <= '0; pnh_q <= '0; pnl_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_TSH:   tsh_q <= wr_data;
        A_TSL:   tsl_q <= wr_data;
        A_TNH:   tnh_q <= wr_data[NSHI_W-1:0];
        A_PSH:   psh_q <= wr_data;
        A_PSL:   psl_q <= wr_data;
        A_PNH:   pnh_q <= wr_data[NSHI_W-1:0];
        A_PNL:   pnl_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign tgt_load      = wr_en && (wr_addr == A_TNL);
  assign tgt_value.sec = {tsh_q, tsl_q};
  assign tgt_value.ns  = {tnh_q, wr_data};
  assign period        = {psh_q, psl_q, pnh_q, pnl_q};

  // R4: period only changes through its own words
  p_period_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == A_PSH || wr_addr == A_PSL ||
                wr_addr == A_PNH || wr_addr == A_PNL)) |=> $stable(period));
endmodule

// File: rtl/pulse_sched_engine.sv
`timescale 1ns/1ps
module pulse_sched_engine
  import pulse_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tgt_load,
  input  ptime_t     tgt_value,
  input  ptime_t     period,
  input  ptime_t     now_t,
  input  logic       one_shot,
  input  logic       pol,
  input  logic [3:0] wcode,
  output logic       pin
);
  localparam ptime_t PARKED = {{SEC_W{1'b1}}, {NS_W{1'b0}}};

  ptime_t tgt_q, end_q, wdur;
  logic   armed_q, active_q, active_n, fire;

  assign wdur.sec = '0;
  assign wdur.ns  = NS_W'(width_ns(wcode));

  // a fresh commit takes priority over a match in the same cycle
  assign fire = armed_q && !tgt_load && (tgt_q.sec != {SEC_W{1'b1}}) &&
                time_ge(now_t, tgt_q);

  always_comb begin
    active_n = active_q;
    if (fire)
      active_n = 1'b1;
    else if (active_q && time_ge(now_t, end_q))
      active_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q    <= PARKED;
      end_q    <= '0;
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      pin      <= 1'b1;
    end else begin
      if (tgt_load) begin
        tgt_q   <= tgt_value;
        armed_q <= 1'b1;
      end else if (fire) begin
        if (one_shot) armed_q <= 1'b0;
        else          tgt_q   <= time_add(tgt_q, period);
      end
      if (fire) end_q <= time_add(tgt_q, wdur);
      active_q <= active_n;
      pin      <= active_n ~^ pol;
    end
  end

  // R6: a match drives the pin to its active level on the next edge
  p_match_drives_pin_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> (pin == $past(pol)));

  // R7: an expired pulse without a new match falls back to idle
  p_pulse_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (active_q && !fire && time_ge(now_t, end_q)) |=> !active_q);

  // R9: a periodic match never moves the target backwards
  p_target_forward_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && !one_shot) |=> time_ge(tgt_q, $past(tgt_q)));

  // R10: a single-shot match disarms the channel
  p_single_disarms_r10: assert property (@(posedge clk) disable iff (rst)
    (fire && one_shot) |=> !armed_q);

  // R11: a parked target starts no pulse
  p_parked_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !tgt_load && (tgt_q.sec == {SEC_W{1'b1}})) |=> !active_q);
endmodule

// File: rtl/pulse_sched.sv
`timescale 1ns/1ps
module pulse_sched
  import pulse_sched_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int CFG_ADDR   = 'h01,
  parameter int TGT_BASE_0 = 'h15,
  parameter int PER_BASE_0 = 'h19,
  parameter int TGT_BASE_1 = 'h1F,
  parameter int PER_BASE_1 = 'h23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [31:0]       now_sec,
  input  logic [29:0]       now_ns,
  output logic [1:0]        pulse_out
);
  localparam int N_CH  = 2;
  localparam int CFG_W = 4 + 4 * N_CH;
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_ADDR);

  logic [CFG_W-1:0] cfg_q;
  ptime_t           now_t;

  assign now_t.sec = now_sec;
  assign now_t.ns  = now_ns;

  // shared control word: interleaved stop-reload/polarity pairs, then width codes
  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (wr_en && (wr_addr == A_CFG))
      cfg_q <= wr_data[CFG_W-1:0];
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic   tgt_load;
    ptime_t tgt_value, period;

    pulse_sched_chregs #(
      .ADDR_W   (ADDR_W),
      .TGT_BASE (c == 0 ? TGT_BASE_0 : TGT_BASE_1),
      .PER_BASE (c == 0 ? PER_BASE_0 : PER_BASE_1)
    ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .tgt_load  (tgt_load),
      .tgt_value (tgt_value),
      .period    (period)
    );

    pulse_sched_engine u_eng (
      .clk       (clk),
      .rst       (rst),
      .tgt_load  (tgt_load),
      .tgt_value (tgt_value),
      .period    (period),
      .now_t     (now_t),
      .one_shot  (cfg_q[2*c]),
      .pol       (cfg_q[2*c+1]),
      .wcode     (cfg_q[4+4*c +: 4]),
      .pin       (pulse_out[c])
    );
  end

  // R2: control bits move only on a write to the control word
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == A_CFG)) |=> $stable(cfg_q));
endmodule

// File: tb/pulse_sched_tb.sv
`timescale 1ns/1ps
module pulse_sched_tb;
  localparam longint SEC = 64'd1000000000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [31:0] now_sec;
  logic [29:0] now_ns;
  logic [1:0]  pulse_out;

  longint tb_now = 0;
  longint jump_to = 0;
  bit     jump_pend = 1'b0;
  bit     clr_req = 1'b0;
  bit     pol_exp [2];
  logic [1:0]  prev_pin = 2'b11;
  logic [15:0] cfg_sh = '0;
  longint rise_t [2][4];
  longint fall_t [2][4];
  int     rise_cnt [2];
  int     fall_cnt [2];
  int     cyc = 0;
  int     checks = 0;
  int     errors = 0;

  always #2.5 clk = ~clk;

  assign now_sec = 32'(tb_now / SEC);
  assign now_ns  = 30'(tb_now % SEC);

  pulse_sched u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .now_sec(now_sec), .now_ns(now_ns), .pulse_out(pulse_out)
  );

  // edge monitor, time source and watchdog, all away from the sampling edge
  always @(negedge clk) begin
    cyc++;
    if (clr_req) begin
      for (int ch = 0; ch < 2; ch++) begin
        rise_cnt[ch] = 0;
        fall_cnt[ch] = 0;
      end
      clr_req = 1'b0;
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        if (pulse_out[ch] !== prev_pin[ch]) begin
          if (pulse_out[ch] == pol_exp[ch]) begin
            if (rise_cnt[ch] < 4) rise_t[ch][rise_cnt[ch]] = tb_now;
            rise_cnt[ch]++;
          end else begin
            if (fall_cnt[ch] < 4) fall_t[ch][fall_cnt[ch]] = tb_now;
            fall_cnt[ch]++;
          end
        end
      end
    end
    prev_pin = pulse_out;
    if (jump_pend) begin
      tb_now    = jump_to;
      jump_pend = 1'b0;
    end else begin
      tb_now = tb_now + 4;
    end
    if (cyc == 190000) begin
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic longint wid(input int code);
    case (code)
      0: return 100;        1: return 500;        2: return 1000;
      3: return 5000;       4: return 10000;      5: return 50000;
      6: return 100000;     7: return 500000;     8: return 1000000;
      9: return 5000000;    10: return 10000000;  11: return 50000000;
      12: return 100000000; default: return 200000000;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 16'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic clear_logs();
    clr_req = 1'b1;
    tick(2);
  endtask

  task automatic set_cfg(input int ch, input bit single, input bit pol, input int code);
    cfg_sh[2*ch]        = single;
    cfg_sh[2*ch+1]      = pol;
    cfg_sh[4+4*ch +: 4] = 4'(code);
    wr('h01, int'(cfg_sh));
    pol_exp[ch] = pol;
    tick(3);
    clear_logs();
  endtask

  task automatic wr_time(input int base, input longint t, input bit junk);
    longint s, n;
    s = t / SEC;
    n = t % SEC;
    wr(base,     int'((s >> 16) & 'hFFFF));
    wr(base + 1, int'(s & 'hFFFF));
    wr(base + 2, int'((n >> 16) & 'h3FFF) | (junk ? 'hC000 : 0));
    wr(base + 3, int'(n & 'hFFFF));
  endtask

  task automatic wr_target(input int ch, input longint t, input bit junk);
    wr_time(ch == 0 ? 'h15 : 'h1F, t, junk);
  endtask

  task automatic wr_period(input int ch, input longint p);
    wr_time(ch == 0 ? 'h19 : 'h23, p, 1'b0);
  endtask

  task automatic park(input int ch);
    int base;
    base = (ch == 0) ? 'h15 : 'h1F;
    wr(base, 'hFFFF); wr(base + 1, 'hFFFF); wr(base + 2, 0); wr(base + 3, 0);
  endtask

  task automatic jump(input longint t);
    jump_to = t;
    jump_pend = 1'b1;
    tick(2);
  endtask

  task automatic wait_cnt(input int ch, input bit want_rise, input int n, input int limit);
    for (int k = 0; k < limit; k++) begin
      if ((want_rise ? rise_cnt[ch] : fall_cnt[ch]) >= n) break;
      tick(1);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    pol_exp[0] = 1'b0;
    pol_exp[1] = 1'b0;
    tick(5);
    rst = 1'b0;
    tick(1);
    chk("R1 idle level after reset", longint'(pulse_out), 3);
    clear_logs();
    tick(100);
    chk("R1 no pulse before commit", longint'(rise_cnt[0] + rise_cnt[1]), 0);

    // two channels, both polarities, 200 ns period on channel 0
    jump(5 * SEC);
    set_cfg(0, 1'b0, 1'b1, 0);
    set_cfg(1, 1'b0, 1'b0, 2);
    wr_period(0, 200);
    wr_period(1, 3000);
    wr_target(0, 5 * SEC + 1000, 1'b0);
    wr_target(1, 5 * SEC + 2000, 1'b0);
    wait_cnt(1, 1'b1, 2, 3000);
    chk("R6 R2 ch0 first rise",  rise_t[0][0], 5 * SEC + 1000);
    chk("R7 R8 ch0 first fall",  fall_t[0][0], 5 * SEC + 1100);
    chk("R12 R4 ch0 min period", rise_t[0][1], 5 * SEC + 1200);
    chk("R7 ch0 second fall",    fall_t[0][1], 5 * SEC + 1300);
    chk("R8 R2 ch1 active-low start", rise_t[1][0], 5 * SEC + 2000);
    chk("R7 ch1 1us width end",  fall_t[1][0], 5 * SEC + 3000);
    chk("R9 R4 ch1 period",      rise_t[1][1], 5 * SEC + 5000);

    // parking both channels
    park(0);
    park(1);
    tick(300);
    clear_logs();
    tick(2000);
    chk("R11 parked ch0 silent", longint'(rise_cnt[0]), 0);
    chk("R11 parked ch1 silent", longint'(rise_cnt[1]), 0);
    chk("R11 R8 idle levels", longint'(pulse_out), 2);

    // period crossing a seconds boundary, junk in nanoseconds-high bits
    jump(7 * SEC + 999999000);
    wr_period(0, 800);
    clear_logs();
    wr_target(0, 7 * SEC + 999999600, 1'b1);
    wait_cnt(0, 1'b1, 3, 2000);
    chk("R5 R6 target with junk bits", rise_t[0][0], 7 * SEC + 999999600);
    chk("R9 carry into seconds",       rise_t[0][1], 8 * SEC + 400);
    chk("R9 next after carry",         rise_t[0][2], 8 * SEC + 1200);
    chk("R7 width after carry",        fall_t[0][1], 8 * SEC + 500);
    park(0);
    tick(100);

    // 200 ms width and whole-second period on channel 0
    set_cfg(0, 1'b0, 1'b1, 13);
    jump(10 * SEC - 2000);
    wr_period(0, SEC);
    wr_target(0, 10 * SEC, 1'b0);
    wait_cnt(0, 1'b1, 1, 1000);
    chk("R6 ch0 rise at 10 s", rise_t[0][0], 10 * SEC);
    jump(10 * SEC + 200000000 - 400);
    wait_cnt(0, 1'b0, 1, 1000);
    chk("R7 code 13 width 200 ms", fall_t[0][0], 10 * SEC + 200000000);
    jump(11 * SEC - 400);
    wait_cnt(0, 1'b1, 2, 1000);
    chk("R9 one second period", rise_t[0][1], 11 * SEC);
    park(0);
    jump(11 * SEC + 250000000);
    tick(5);

    // code 15 on channel 1
    set_cfg(1, 1'b0, 1'b0, 15);
    jump(20 * SEC - 2000);
    wr_period(1, SEC);
    wr_target(1, 20 * SEC, 1'b0);
    wait_cnt(1, 1'b1, 1, 1000);
    chk("R6 ch1 rise at 20 s", rise_t[1][0], 20 * SEC);
    jump(20 * SEC + 200000000 - 400);
    wait_cnt(1, 1'b0, 1, 1000);
    chk("R7 code 15 maps to 200 ms", fall_t[1][0] - rise_t[1][0], 200000000);
    park(1);
    jump(21 * SEC + 500000000);
    tick(5);

    // staged target write and single shot
    set_cfg(0, 1'b1, 1'b1, 1);
    jump(30 * SEC);
    wr('h15, 0);
    wr('h16, 30);
    wr('h17, 0);
    tick(40);
    chk("R3 partial target does not arm", longint'(rise_cnt[0]), 0);
    wr('h18, 0);
    wait_cnt(0, 1'b0, 1, 300);
    chk("R3 commit arms channel", longint'(rise_cnt[0]), 1);
    chk("R7 end from matched target", fall_t[0][0], 30 * SEC + 500);
    tick(1500);
    chk("R10 single shot fires once", longint'(rise_cnt[0]), 1);

    // random channel, polarity, width and period
    for (int i = 0; i < 8; i++) begin
      int     ch, code;
      bit     pol;
      longint w, per, base, tgt;
      ch   = int'($urandom % 2);
      code = int'($urandom % 4);
      pol  = 1'($urandom % 2);
      w    = wid(code);
      per  = w + 200 + 4 * longint'($urandom % 500);
      base = longint'(40 + i) * SEC + 999990000 + 4 * longint'($urandom % 2500);
      tgt  = base + 2000;
      set_cfg(ch, 1'b0, pol, code);
      jump(base);
      wr_period(ch, per);
      wr_target(ch, tgt, 1'b0);
      wait_cnt(ch, 1'b1, 2, 5000);
      chk("R6 random first rise",  rise_t[ch][0], tgt);
      chk("R7 random width",       fall_t[ch][0] - rise_t[ch][0], w);
      chk("R9 random period",      rise_t[ch][1] - rise_t[ch][0], per);
      chk("R12 other channel quiet", longint'(rise_cnt[1-ch]), 0);
      park(ch);
      tick(int'(w / 4) + 20);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule